// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block runs the two multi-cycle sequences a small 8/16-bit processor core needs around interrupts. On entry it saves the interrupted context on the stack over a byte-wide memory port, chooses one pending source by fixed priority, fetches the handler address as a little-endian word from bank zero, and loads the program counter and program bank. On return it restores the saved context from the stack in the reverse order. Native and emulation modes differ: in native mode the program bank byte is part of the frame, and emulation mode leaves it out.

The core drives `enter` or `ret` for one cycle while the sequencer is idle. It presents the live context (PC, bank, status, stack pointer) and the pending source lines. The updated context appears on the `*_out` ports once `busy` drops. The memory port is a plain single-cycle model: read data is combinational on the address and is taken at the clock edge that ends the access cycle. The count of cycles the last sequence took is reported.

Top module: `intr_seq_top`

## Requirements
- R1: In the idle cycle where `enter` is high, one source is picked by priority, highest first: hw_pend bit0 (reset), bit1 (abort), bit2 (NMI), bit3 (vertical blank), bit4 (IRQ), bit5 (timer), then `sw_cop`, then `sw_brk`. Bits 4 and 5 are not eligible while status bit 2 (I flag) of `psr_in` is set.
- R2: The handler address is read from bank zero: 0xFFFC for reset, 0xFFE8 for abort, 0xFFEA for NMI and vertical blank, 0xFFEE for IRQ and timer, 0xFFE4 for COP, and 0xFFE6 for BRK. The low byte is read at the vector address and the high byte at the vector address plus one. After entry, `pbr_out` is zero.
- R3: In native mode (`emu`=0), entry writes four bytes in this order: bank, PC high, PC low, status. Each byte is written at address {0x00, SP}, and SP is then decremented, so `sp_out` = `sp_in` − 4.
- R4: In emulation mode (`emu`=1), entry writes only PC high, PC low and status, with the same stack addressing, so `sp_out` = `sp_in` − 3.
- R5: After entry, status bit 2 (I) is set. Status bit 3 (D) is cleared in native mode and for a reset entry; otherwise it is kept. All other status bits are kept.
- R6: A reset entry writes nothing, leaves SP unchanged, and pulses `stop_clr` high for exactly one cycle, in the last busy cycle. No other sequence asserts `stop_clr`.
- R7: Return first increments SP and then reads {0x00, SP}, for each byte. The bytes are read in the order status, PC low, PC high, and then bank in native mode only. In emulation mode `pbr_out` keeps `pbr_in`.
- R8: `busy` stays high for the following number of cycles, and `cyc_count` reports that number afterwards: entry 8 (native) or 7 (emulation), reset entry 4, return 7 (native) or 6 (emulation).
- R9: `done` is high for exactly one cycle, which is the last cycle with `busy` high.
- R10: An `enter` with no eligible source starts nothing: `busy` stays low, no write occurs, and the outputs hold.
- R11: If `enter` (with an eligible source) and `ret` are both high, the entry runs. If `enter` has no eligible source, `ret` runs.
- R12: Synchronous reset forces idle: `busy`, `done` and `mem_we` are low, `pc_out`, `pbr_out` and `psr_out` are zero, and `sp_out` = 0x01FF. This also applies when reset is applied in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter | input | 1 | Interrupt entry request |
| ret | input | 1 | Return-from-interrupt request |
| hw_pend | input | 6 | Pending hardware sources |
| sw_cop | input | 1 | Software COP request |
| sw_brk | input | 1 | Software break request |
| emu | input | 1 | 1 = emulation mode |
| pc_in | input | 16 | Current program counter |
| pbr_in | input | 8 | Current program bank |
| psr_in | input | 8 | Current status register |
| sp_in | input | 16 | Current stack pointer |
| mem_rdata | input | 8 | Memory read data |
| mem_addr | output | 24 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last cycle of a sequence |
| stop_clr | output | 1 | Release stopped core (reset entry) |
| cyc_count | output | 4 | Length of last sequence in cycles |
| pc_out | output | 16 | Resulting program counter |
| pbr_out | output | 8 | Resulting program bank |
| psr_out | output | 8 | Resulting status register |
| sp_out | output | 16 | Resulting stack pointer |

## Verification
The hardest situation to reach from the ports is priority resolution combined with masking. The maskable lines must be ignored while a lower-priority software request or a higher-priority line is pending at the same time. The stimulus table sets several source bits at once with the I flag both set and clear. It also includes a row that raises `enter` and `ret` together with no eligible source, so that the return path must take over. A reset applied in the middle of an entry checks that no partial frame or stale strobe survives.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int PC_W    = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 24;
    localparam int NHW     = 6;
    localparam int NSRC    = 8;
    localparam int CNT_W   = 4;
    localparam int FLAG_I  = 2;
    localparam int FLAG_D  = 3;
    localparam logic [BYTE_W-1:0] BANK0 = '0;
    // sources that the I flag blocks (IRQ and timer)
    localparam logic [NSRC-1:0] MASKABLE = 8'b0011_0000;

    typedef enum logic [2:0] {
        SRC_RESET, SRC_ABORT, SRC_NMI, SRC_VBL,
        SRC_IRQ, SRC_HVT, SRC_COP, SRC_BRK
    } src_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_E_PRE0, ST_E_PRE1, ST_E_PUSH, ST_E_VLO, ST_E_VHI,
        ST_R_PRE0, ST_R_PRE1, ST_R_PULL, ST_R_FIN
    } st_e;

    typedef enum logic [1:0] {FLD_PBR, FLD_PCH, FLD_PCL, FLD_PSR} fld_e;

    typedef struct packed {
        logic [BYTE_W-1:0] pbr;
        logic [PC_W-1:0]   pc;
        logic [BYTE_W-1:0] psr;
        logic [PC_W-1:0]   sp;
    } ctx_t;

    function automatic logic [PC_W-1:0] vec_of(src_e s);
        case (s)
            SRC_COP:          return 16'hFFE4;
            SRC_BRK:          return 16'hFFE6;
            SRC_ABORT:        return 16'hFFE8;
            SRC_NMI, SRC_VBL: return 16'hFFEA;
            SRC_IRQ, SRC_HVT: return 16'hFFEE;
            default:          return 16'hFFFC;
        endcase
    endfunction

    // entry frame: bank, PC high, PC low, status; emulation skips the bank
    function automatic fld_e push_fld(logic [1:0] k, logic emu);
        logic [1:0] i;
        i = k + {1'b0, emu};
        return fld_e'(i);
    endfunction

    // return frame: status, PC low, PC high, bank
    function automatic fld_e pull_fld(logic [1:0] k);
        case (k)
            2'd0:    return FLD_PSR;
            2'd1:    return FLD_PCL;
            2'd2:    return FLD_PCH;
            default: return FLD_PBR;
        endcase
    endfunction

endpackage

// File: rtl/intr_prio.sv
module intr_prio
    import intr_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NHW-1:0] hw_pend,
    input  logic           sw_cop,
    input  logic           sw_brk,
    input  logic           irq_off,
    output logic           any,
    output src_e           src
);

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] elig;

    assign raw = {sw_brk, sw_cop, hw_pend};

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_mask
            if (MASKABLE[g]) begin : g_m
                assign elig[g] = raw[g] & ~irq_off;
            end else begin : g_n
                assign elig[g] = raw[g];
            end
        end
    endgenerate

    always_comb begin
        any = |elig;
        src = SRC_BRK;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (elig[i]) src = src_e'(i[2:0]);
        end
    end

    // R1
    masked_src_chk: assert property (@(posedge clk) disable iff (rst)
        (any && (src == SRC_IRQ || src == SRC_HVT)) |-> !irq_off);

    // R1
    reset_wins_chk: assert property (@(posedge clk) disable iff (rst)
        hw_pend[0] |-> (any && src == SRC_RESET));

endmodule

// File: rtl/intr_fsm.sv
module intr_fsm
    import intr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enter,
    input  logic             ret,
    input  logic             any,
    input  logic             emu_in,
    input  logic             is_reset_in,
    output st_e              st,
    output logic [1:0]       k,
    output logic             busy,
    output logic             done,
    output logic             load,
    output logic             emu_q,
    output logic             rst_src_q,
    output logic             stop_clr,
    output logic [CNT_W-1:0] cyc_count
);

    st_e              st_n;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       last_k;
    logic             go_entry;

    assign last_k   = emu_q ? 2'd2 : 2'd3;
    assign go_entry = enter && any;
    assign busy     = (st != ST_IDLE);
    assign done     = (st == ST_E_VHI) || (st == ST_R_FIN);
    assign stop_clr = (st == ST_E_VHI) && rst_src_q;
    assign load     = (st == ST_IDLE) && (go_entry || ret);

    always_comb begin
        st_n = st;
        case (st)
            ST_IDLE: begin
                if (go_entry)  st_n = ST_E_PRE0;
                else if (ret)  st_n = ST_R_PRE0;
            end
            ST_E_PRE0: st_n = ST_E_PRE1;
            ST_E_PRE1: st_n = rst_src_q ? ST_E_VLO : ST_E_PUSH;
            ST_E_PUSH: if (k == last_k) st_n = ST_E_VLO;
            ST_E_VLO:  st_n = ST_E_VHI;
            ST_E_VHI:  st_n = ST_IDLE;
            ST_R_PRE0: st_n = ST_R_PRE1;
            ST_R_PRE1: st_n = ST_R_PULL;
            ST_R_PULL: if (k == last_k) st_n = ST_R_FIN;
            ST_R_FIN:  st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            k         <= 2'd0;
            cnt       <= '0;
            emu_q     <= 1'b0;
            rst_src_q <= 1'b0;
            cyc_count <= '0;
        end else begin
            st <= st_n;
            if (load) begin
                emu_q     <= emu_in;
                rst_src_q <= go_entry && is_reset_in;
                cnt       <= CNT_W'(1);
            end else if (busy) begin
                cnt <= cnt + CNT_W'(1);
            end
            if (done) cyc_count <= cnt;
            if ((st == ST_E_PUSH || st == ST_R_PULL) && k != last_k)
                k <= k + 2'd1;
            else
                k <= 2'd0;
        end
    end

    // R9
    done_ends_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R8
    ret_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_R_FIN) |-> (cnt == (emu_q ? CNT_W'(6) : CNT_W'(7))));

    // R8
    entry_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_E_VHI) |->
        (cnt == (rst_src_q ? CNT_W'(4) : (emu_q ? CNT_W'(7) : CNT_W'(8)))));

endmodule

// File: rtl/intr_ctx.sv
module intr_ctx
    import intr_seq_pkg::*;
#(
    parameter logic [PC_W-1:0] SP_INIT = 16'h01FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  st_e               st,
    input  logic [1:0]        k,
    input  logic              emu_q,
    input  logic              rst_src_q,
    input  src_e              src,
    input  ctx_t              ctx_in,
    input  logic [BYTE_W-1:0] rdata,
    output ctx_t              ctx,
    output logic [ADDR_W-1:0] maddr,
    output logic              mwe,
    output logic              mre,
    output logic [BYTE_W-1:0] mwdata
);

    logic [PC_W-1:0] vec_q;

    always_comb begin
        mwe    = 1'b0;
        mre    = 1'b0;
        maddr  = '0;
        mwdata = '0;
        case (st)
            ST_E_PUSH: begin
                mwe   = 1'b1;
                maddr = {BANK0, ctx.sp};
                case (push_fld(k, emu_q))
                    FLD_PBR: mwdata = ctx.pbr;
                    FLD_PCH: mwdata = ctx.pc[15:8];
                    FLD_PCL: mwdata = ctx.pc[7:0];
                    default: mwdata = ctx.psr;
                endcase
            end
            ST_E_VLO: begin
                mre   = 1'b1;
                maddr = {BANK0, vec_q};
            end
            ST_E_VHI: begin
                mre   = 1'b1;
                maddr = {BANK0, vec_q + 16'd1};
            end
            ST_R_PULL: begin
                mre   = 1'b1;
                maddr = {BANK0, ctx.sp + 16'd1};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx.pbr <= '0;
            ctx.pc  <= '0;
            ctx.psr <= '0;
            ctx.sp  <= SP_INIT;
            vec_q   <= '0;
        end else if (load) begin
            ctx   <= ctx_in;
            vec_q <= vec_of(src);
        end else begin
            case (st)
                ST_E_PUSH: ctx.sp <= ctx.sp - 16'd1;
                ST_E_VLO:  ctx.pc[7:0] <= rdata;
                ST_E_VHI: begin
                    ctx.pc[15:8]       <= rdata;
                    ctx.pbr            <= BANK0;
                    ctx.psr[FLAG_I]    <= 1'b1;
                    if (!emu_q || rst_src_q) ctx.psr[FLAG_D] <= 1'b0;
                end
                ST_R_PULL: begin
                    ctx.sp <= ctx.sp + 16'd1;
                    case (pull_fld(k))
                        FLD_PSR: ctx.psr       <= rdata;
                        FLD_PCL: ctx.pc[7:0]   <= rdata;
                        FLD_PCH: ctx.pc[15:8]  <= rdata;
                        default: ctx.pbr       <= rdata;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // R3
    push_sp_chk: assert property (@(posedge clk) disable iff (rst)
        mwe |=> (ctx.sp == $past(ctx.sp) - 16'd1));

    // R5
    vec_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_E_VHI) |=> (ctx.pbr == BANK0 && ctx.psr[FLAG_I]));

    // R7
    pull_sp_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_R_PULL) |=> (ctx.sp == $past(ctx.sp) + 16'd1));

endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
    import intr_seq_pkg::*;
#(
    parameter logic [15:0] SP_INIT = 16'h01FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enter,
    input  logic              ret,
    input  logic [NHW-1:0]    hw_pend,
    input  logic              sw_cop,
    input  logic              sw_brk,
    input  logic              emu,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [BYTE_W-1:0] pbr_in,
    input  logic [BYTE_W-1:0] psr_in,
    input  logic [PC_W-1:0]   sp_in,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic              stop_clr,
    output logic [CNT_W-1:0]  cyc_count,
    output logic [PC_W-1:0]   pc_out,
    output logic [BYTE_W-1:0] pbr_out,
    output logic [BYTE_W-1:0] psr_out,
    output logic [PC_W-1:0]   sp_out
);

    logic       any;
    src_e       src;
    st_e        st;
    logic [1:0] k;
    logic       load, emu_q, rst_src_q;
    ctx_t       ctx_in, ctx;

    assign ctx_in = '{pbr: pbr_in, pc: pc_in, psr: psr_in, sp: sp_in};

    intr_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .hw_pend (hw_pend),
        .sw_cop  (sw_cop),
        .sw_brk  (sw_brk),
        .irq_off (psr_in[FLAG_I]),
        .any     (any),
        .src     (src)
    );

    intr_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enter       (enter),
        .ret         (ret),
        .any         (any),
        .emu_in      (emu),
        .is_reset_in (src == SRC_RESET),
        .st          (st),
        .k           (k),
        .busy        (busy),
        .done        (done),
        .load        (load),
        .emu_q       (emu_q),
        .rst_src_q   (rst_src_q),
        .stop_clr    (stop_clr),
        .cyc_count   (cyc_count)
    );

    intr_ctx #(.SP_INIT(SP_INIT)) u_ctx (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .st        (st),
        .k         (k),
        .emu_q     (emu_q),
        .rst_src_q (rst_src_q),
        .src       (src),
        .ctx_in    (ctx_in),
        .rdata     (mem_rdata),
        .ctx       (ctx),
        .maddr     (mem_addr),
        .mwe       (mem_we),
        .mre       (mem_re),
        .mwdata    (mem_wdata)
    );

    assign pc_out  = ctx.pc;
    assign pbr_out = ctx.pbr;
    assign psr_out = ctx.psr;
    assign sp_out  = ctx.sp;

    // R10
    we_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we || mem_re) |-> busy);

    // R3
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    // R6
    stop_clr_chk: assert property (@(posedge clk) disable iff (rst)
        stop_clr |-> (done && !mem_we && $stable(sp_out)));

endmodule

// File: tb/intr_seq_top_test.sv
`timescale 1ns/1ps
module intr_seq_top_test;

    typedef struct packed {
        logic        is_ret;
        logic        both;
        logic        emu;
        logic [5:0]  hw;
        logic        cop;
        logic        brk;
        logic [7:0]  psr;
        logic [15:0] pc;
        logic [7:0]  pbr;
        logic [15:0] sp;
    } row_t;

    localparam int NROW = 15;
    localparam row_t TBL [NROW] = '{
        '{1'b0, 1'b0, 1'b0, 6'b010000, 1'b0, 1'b0, 8'h0B, 16'h1234, 8'h7E, 16'h01F0},
        '{1'b0, 1'b0, 1'b1, 6'b010000, 1'b0, 1'b0, 8'h0B, 16'hABCD, 8'h33, 16'h01E8},
        '{1'b0, 1'b0, 1'b0, 6'b010000, 1'b0, 1'b0, 8'h04, 16'h2222, 8'h11, 16'h01F0},
        '{1'b0, 1'b0, 1'b1, 6'b110000, 1'b0, 1'b0, 8'h0C, 16'h3333, 8'h12, 16'h01F0},
        '{1'b0, 1'b0, 1'b0, 6'b000100, 1'b0, 1'b0, 8'h04, 16'h4444, 8'h21, 16'h01F4},
        '{1'b0, 1'b0, 1'b1, 6'b001000, 1'b0, 1'b0, 8'h08, 16'h5555, 8'h22, 16'h01F8},
        '{1'b0, 1'b0, 1'b0, 6'b010110, 1'b1, 1'b0, 8'h00, 16'h6666, 8'h23, 16'h01C0},
        '{1'b0, 1'b0, 1'b0, 6'b000101, 1'b0, 1'b0, 8'h08, 16'h7777, 8'h24, 16'h01B0},
        '{1'b0, 1'b0, 1'b0, 6'b000000, 1'b1, 1'b1, 8'h0C, 16'h8888, 8'h25, 16'h01A0},
        '{1'b0, 1'b0, 1'b1, 6'b000000, 1'b0, 1'b1, 8'h08, 16'h9999, 8'h26, 16'h0190},
        '{1'b0, 1'b0, 1'b0, 6'b100000, 1'b0, 1'b1, 8'h00, 16'hAAAA, 8'h27, 16'h0180},
        '{1'b1, 1'b0, 1'b1, 6'b000000, 1'b0, 1'b0, 8'hC3, 16'h4567, 8'h99, 16'h01E0},
        '{1'b1, 1'b0, 1'b0, 6'b000000, 1'b0, 1'b0, 8'h2A, 16'h89AB, 8'h5C, 16'h01D0},
        '{1'b0, 1'b1, 1'b0, 6'b010000, 1'b0, 1'b0, 8'h00, 16'hBEEF, 8'h41, 16'h0170},
        '{1'b1, 1'b1, 1'b0, 6'b000000, 1'b0, 1'b0, 8'h6D, 16'hC0DE, 8'h42, 16'h0160}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enter = 1'b0, ret = 1'b0;
    logic [5:0]  hw_pend = '0;
    logic        sw_cop = 1'b0, sw_brk = 1'b0, emu = 1'b0;
    logic [15:0] pc_in = '0, sp_in = '0;
    logic [7:0]  pbr_in = '0, psr_in = '0;
    logic [7:0]  mem_rdata;
    logic [23:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic        busy, done, stop_clr;
    logic [3:0]  cyc_count;
    logic [15:0] pc_out, sp_out;
    logic [7:0]  pbr_out, psr_out;

    logic        pre_we = 1'b0;
    logic [7:0]  pre_a = '0, pre_d = '0;
    logic [7:0]  stk [256];

    int nchk = 0;
    int nfail = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    intr_seq_top uut (
        .clk(clk), .rst(rst), .enter(enter), .ret(ret), .hw_pend(hw_pend),
        .sw_cop(sw_cop), .sw_brk(sw_brk), .emu(emu), .pc_in(pc_in),
        .pbr_in(pbr_in), .psr_in(psr_in), .sp_in(sp_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .busy(busy), .done(done), .stop_clr(stop_clr),
        .cyc_count(cyc_count), .pc_out(pc_out), .pbr_out(pbr_out),
        .psr_out(psr_out), .sp_out(sp_out)
    );

    function automatic logic [7:0] vb(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    always @(posedge clk) begin
        if (pre_we) stk[pre_a] <= pre_d;
        else if (mem_we && mem_addr[23:8] == 16'h0001) stk[mem_addr[7:0]] <= mem_wdata;
    end

    always_comb begin
        if (mem_addr[23:8] == 16'h0001) mem_rdata = stk[mem_addr[7:0]];
        else mem_rdata = vb(mem_addr[15:0]);
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // priority per R1: 0..7 source code, 8 none
    function automatic int pick(row_t r);
        if (r.hw[0]) return 0;
        if (r.hw[1]) return 1;
        if (r.hw[2]) return 2;
        if (r.hw[3]) return 3;
        if (r.hw[4] && !r.psr[2]) return 4;
        if (r.hw[5] && !r.psr[2]) return 5;
        if (r.cop) return 6;
        if (r.brk) return 7;
        return 8;
    endfunction

    function automatic logic [15:0] vaddr(int c);
        case (c)
            0: return 16'hFFFC;
            1: return 16'hFFE8;
            2, 3: return 16'hFFEA;
            4, 5: return 16'hFFEE;
            6: return 16'hFFE4;
            default: return 16'hFFE6;
        endcase
    endfunction

    task automatic poke(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_a = a; pre_d = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic run_row(row_t r);
        logic [15:0] p_pc, p_sp, e_pc, e_sp;
        logic [7:0]  p_pbr, p_psr, e_pbr, e_psr;
        logic [23:0] wa [8];
        logic [7:0]  wd [8];
        logic [7:0]  eb [4];
        int nb, nd, done_at, nw, nstop, code, n, ecyc;
        bit go_in, go_ret;
        string tag;
        if (r.is_ret) begin
            poke(8'(r.sp + 16'd1), r.psr);
            poke(8'(r.sp + 16'd2), r.pc[7:0]);
            poke(8'(r.sp + 16'd3), r.pc[15:8]);
            poke(8'(r.sp + 16'd4), r.pbr);
        end
        @(negedge clk);
        p_pc = pc_out; p_sp = sp_out; p_pbr = pbr_out; p_psr = psr_out;
        enter = !r.is_ret || r.both;
        ret   = r.is_ret || r.both;
        emu = r.emu; hw_pend = r.hw; sw_cop = r.cop; sw_brk = r.brk;
        if (r.is_ret) begin
            pc_in = 16'h0F0F; pbr_in = 8'hA5; psr_in = ~r.psr;
        end else begin
            pc_in = r.pc; pbr_in = r.pbr; psr_in = r.psr;
        end
        sp_in = r.sp;
        @(negedge clk);
        enter = 1'b0; ret = 1'b0;
        nb = 0; nd = 0; done_at = 0; nw = 0; nstop = 0;
        while (busy && nb < 20) begin
            nb++;
            if (done) begin nd++; done_at = nb; end
            if (stop_clr) nstop++;
            if (mem_we && nw < 8) begin wa[nw] = mem_addr; wd[nw] = mem_wdata; nw++; end
            @(negedge clk);
        end
        code  = pick(r);
        go_in = (!r.is_ret || r.both) && code < 8;
        go_ret = !go_in && (r.is_ret || r.both);
        if (go_in) begin
            tag = r.both ? "R11 R1 R2" : "R1 R2";
            n = (code == 0) ? 0 : (r.emu ? 3 : 4);
            ecyc = 4 + n;
            e_pc = {vb(vaddr(code) + 16'd1), vb(vaddr(code))};
            e_pbr = 8'h00;
            e_psr = r.psr | 8'h04;
            if (!r.emu || code == 0) e_psr = e_psr & 8'hF7;
            e_sp = r.sp - 16'(n);
            if (r.emu) begin
                eb[0] = r.pc[15:8]; eb[1] = r.pc[7:0]; eb[2] = r.psr; eb[3] = 8'h00;
            end else begin
                eb[0] = r.pbr; eb[1] = r.pc[15:8]; eb[2] = r.pc[7:0]; eb[3] = r.psr;
            end
        end else if (go_ret) begin
            tag = r.both ? "R11 R7" : "R7";
            n = r.emu ? 3 : 4;
            ecyc = 3 + n;
            e_pc = r.pc; e_psr = r.psr;
            e_pbr = r.emu ? 8'hA5 : r.pbr;
            e_sp = r.sp + 16'(n);
            n = 0;
        end else begin
            tag = "R10";
            n = 0; ecyc = 0;
            e_pc = p_pc; e_pbr = p_pbr; e_psr = p_psr; e_sp = p_sp;
        end
        check("R8", "busy cycles", 32'(nb), 32'(ecyc));
        if (ecyc > 0) begin
            check("R8", "cyc_count", 32'(cyc_count), 32'(ecyc));
            check("R9", "done pulses", 32'(nd), 32'd1);
            check("R9", "done position", 32'(done_at), 32'(nb));
        end
        check(tag, "pc_out", 32'(pc_out), 32'(e_pc));
        check(tag, "pbr_out", 32'(pbr_out), 32'(e_pbr));
        check(go_in ? "R5" : tag, "psr_out", 32'(psr_out), 32'(e_psr));
        check(go_in ? (r.emu ? "R4" : "R3") : tag, "sp_out", 32'(sp_out), 32'(e_sp));
        check(go_in && code == 0 ? "R6" : (r.emu ? "R4" : "R3"), "write count",
              32'(nw), 32'(n));
        for (int i = 0; i < n && i < nw; i++) begin
            check(r.emu ? "R4" : "R3", "push addr", 32'(wa[i]), 32'({8'h00, r.sp - 16'(i)}));
            check(r.emu ? "R4" : "R3", "push data", 32'(wd[i]), 32'(eb[i]));
        end
        check("R6", "stop_clr pulses", 32'(nstop), (go_in && code == 0) ? 32'd1 : 32'd0);
        hw_pend = '0; sw_cop = 1'b0; sw_brk = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12", "busy", 32'(busy), 32'd0);
        check("R12", "done", 32'(done), 32'd0);
        check("R12", "mem_we", 32'(mem_we), 32'd0);
        check("R12", "pc_out", 32'(pc_out), 32'd0);
        check("R12", "psr_out", 32'(psr_out), 32'd0);
        check("R12", "sp_out", 32'(sp_out), 32'h01FF);
        for (int i = 0; i < NROW; i++) run_row(TBL[i]);
        // R12 reset in the middle of a native entry
        @(negedge clk);
        enter = 1'b1; hw_pend = 6'b000100; emu = 1'b0;
        pc_in = 16'h1357; pbr_in = 8'h66; psr_in = 8'h00; sp_in = 16'h01F0;
        @(negedge clk);
        enter = 1'b0;
        repeat (3) @(negedge clk);
        check("R12", "busy mid-run", 32'(busy), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        hw_pend = '0;
        check("R12", "busy after reset", 32'(busy), 32'd0);
        check("R12", "mem_we after reset", 32'(mem_we), 32'd0);
        check("R12", "sp_out after reset", 32'(sp_out), 32'h01FF);
        check("R12", "pbr_out after reset", 32'(pbr_out), 32'd0);
        repeat (3) @(negedge clk);
        check("R12", "stays idle", 32'(busy), 32'd0);
        finish_up();
    end

endmodule